// File: doc/BRIEF.md
# Multi-Queue Circular Buffer Manager

This block keeps sixty-four independent FIFO queues. All of them are stored as circular buffers in one shared single-port SRAM of 2048 words of 32 bits. Each queue has its own configuration word. That word sets where the ring starts in the SRAM, how many words it holds, and how many words make up one entry.

A single memory-mapped slave port does all the work. Software writes a queue's configuration, pushes by writing to the queue's port, pops by reading from it, and reads or clears its status. The same port also reads and writes raw SRAM words. Bus address bits [13:12] choose the region: 0 is raw SRAM (word address in bits [10:0]), 1 is the queue port, 2 is queue configuration and 3 is queue status. In regions 1 to 3, bits [5:0] select the queue. Read data appears on `bus_rdata` one cycle after the request.

Status leaves the block in two ways. Each queue selects one of its four flags as its condition. The lower thirty-two queues drive one condition line each. The upper thirty-two are merged into a single event line. One interrupt line serves each half and fires only for queues whose enable bit is set.

Top module: `qring_mgr`

## Requirements
- R1: The configuration word uses these fields. Bits [10:0] are the base word address. Bits [12:11] are the size code (0 to 3 give 16, 32, 64 or 128 words). Bits [14:13] are the entry code (0 gives 1 word, 1 gives 2 words, 2 or 3 give 4 words). Bits [21:15] are the nearly-empty threshold and bits [28:22] the nearly-full threshold, both counted in entries. Bit 29 is the interrupt enable and bits [31:30] select the flag (0 empty, 1 nearly-empty, 2 nearly-full, 3 full). Reading the configuration returns the word that was written. Writing it empties the queue and clears both sticky bits.
- R2: Popped words come out in push order. The ring offset wraps modulo the buffer size, so a queue keeps working after many fills and drains.
- R3: A multi-word entry becomes visible only once its last word is written. The word count then rises by the entry size. On a pop it falls by the entry size only after the last word of the entry is read.
- R4: A push that starts a new entry while the queue is full is dropped, and it sets the sticky overflow bit (status bit 5).
- R5: A pop from an empty queue returns zero and sets the sticky underflow bit (status bit 4).
- R6: Writing 1 to status bit 4 or bit 5 clears that bit. Writing 0 leaves it unchanged.
- R7: The status word has empty at bit 0, nearly-empty at bit 1, nearly-full at bit 2, full at bit 3, and the committed word count in bits [15:8]. Nearly-empty means entries ≤ its threshold. Nearly-full means entries ≥ its threshold.
- R8: `lo_flags[i]` equals the selected flag of queue i for i from 0 to 31.
- R9: `hi_event` is the OR of the selected flags of queues 32 to 63.
- R10: `irq_lo` and `irq_hi` are each the OR, over their half, of the selected flag ANDed with the enable bit.
- R11: A raw SRAM write stores the word, and a raw read returns it on the next cycle.
- R12: After reset every configuration word is zero and every queue is empty. The first cycle after reset shows `bus_rdata` as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request strobe, one operation per cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 14 | Region in [13:12]; word address or queue index below |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| lo_flags | output | 32 | Selected condition of queues 0 to 31 |
| hi_event | output | 1 | OR of selected conditions of queues 32 to 63 |
| irq_lo | output | 1 | Enabled conditions of the lower half |
| irq_hi | output | 1 | Enabled conditions of the upper half |

## Verification
The bench builds the block with its default of 64 queues over the full 2048-word SRAM. This puts both the 32-line lower status bus and the 32-queue merged event within reach. It also allows a 128-word maximum ring to sit beside others without overlap. The queues under test use one-word and four-word entries across 16- and 32-word rings. These cover wraparound after a partial fill, atomic commit of a four-word entry, and both sticky error paths. The merged event is driven low by reconfiguring every upper queue, then raised by filling one of them.

// File: rtl/qring_pkg.sv
package qring_pkg;

    localparam int MEM_AW = 11;
    localparam int DW     = 32;
    localparam int THR_W  = 7;
    localparam int OFF_W  = 7;
    localparam int CNT_W  = 8;

    typedef enum logic [1:0] {
        RG_SRAM = 2'd0,
        RG_PORT = 2'd1,
        RG_CFG  = 2'd2,
        RG_STAT = 2'd3
    } region_e;

    typedef struct packed {
        logic [1:0]        sel;
        logic              en;
        logic [THR_W-1:0]  nf;
        logic [THR_W-1:0]  ne;
        logic [1:0]        ec;
        logic [1:0]        szc;
        logic [MEM_AW-1:0] base;
    } qcfg_t;

    typedef struct packed {
        logic full;
        logic nfull;
        logic nempty;
        logic empty;
    } qflag_t;

    function automatic logic [CNT_W-1:0] size_words(input logic [1:0] szc);
        return CNT_W'(16) << szc;
    endfunction

    function automatic logic [1:0] entry_shift(input logic [1:0] ec);
        return (ec == 2'd3) ? 2'd2 : ec;
    endfunction

    function automatic logic [2:0] entry_words(input logic [1:0] ec);
        return 3'd1 << entry_shift(ec);
    endfunction

endpackage

// File: rtl/qring_sram.sv
module qring_sram #(
    parameter int AW = 11,
    parameter int W  = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end
endmodule

// File: rtl/qring_flags.sv
module qring_flags
    import qring_pkg::*;
#(
    parameter int NQ = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  qcfg_t            cfg [NQ],
    input  logic [CNT_W-1:0] cnt [NQ],
    output qflag_t           flags [NQ],
    output logic [NQ-1:0]    sel_cond,
    output logic [NQ-1:0]    en_vec
);
    for (genvar q = 0; q < NQ; q++) begin : g_q
        logic [CNT_W-1:0] sw;
        logic [CNT_W-1:0] ents;
        logic [3:0]       fv;

        always_comb begin
            sw   = size_words(cfg[q].szc);
            ents = cnt[q] >> entry_shift(cfg[q].ec);
            flags[q].empty  = (cnt[q] == '0);
            flags[q].full   = (cnt[q] == sw);
            flags[q].nempty = (ents <= CNT_W'(cfg[q].ne));
            flags[q].nfull  = (ents >= CNT_W'(cfg[q].nf));
            fv              = flags[q];
            sel_cond[q]     = fv[cfg[q].sel];
            en_vec[q]       = cfg[q].en;
        end

        // R3
        no_cnt_over_chk: assert property (@(posedge clk) disable iff (rst)
            cnt[q] <= sw);
    end
endmodule

// File: rtl/qring_mgr.sv
module qring_mgr
    import qring_pkg::*;
#(
    parameter int NQ = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_valid,
    input  logic          bus_write,
    input  logic [13:0]   bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic [NQ/2-1:0] lo_flags,
    output logic          hi_event,
    output logic          irq_lo,
    output logic          irq_hi
);
    localparam int HALF = NQ / 2;
    localparam int QW   = $clog2(NQ);

    qcfg_t            cfg_q  [NQ];
    logic [OFF_W-1:0] wptr   [NQ];
    logic [OFF_W-1:0] rptr   [NQ];
    logic [CNT_W-1:0] cnt    [NQ];
    logic [1:0]       wsub   [NQ];
    logic [1:0]       rsub   [NQ];
    logic [NQ-1:0]    ufl, ofl;

    qflag_t        flags [NQ];
    logic [NQ-1:0] sel_cond, en_vec;

    region_e          rg;
    logic [QW-1:0]    qi;
    qcfg_t            c;
    logic [CNT_W-1:0] sw;
    logic [2:0]       ew;
    logic [OFF_W-1:0] mask, woff, roff;
    logic             do_push, do_pop, push_ok, pop_ok;
    logic             mem_we;
    logic [MEM_AW-1:0] mem_addr;
    logic [DW-1:0]    mem_rdata, side_d, side_q;
    logic             rd_mem_q;

    always_comb begin
        rg      = region_e'(bus_addr[13:12]);
        qi      = bus_addr[QW-1:0];
        c       = cfg_q[qi];
        sw      = size_words(c.szc);
        ew      = entry_words(c.ec);
        mask    = OFF_W'(sw - 1'b1);
        woff    = (wptr[qi] + OFF_W'(wsub[qi])) & mask;
        roff    = (rptr[qi] + OFF_W'(rsub[qi])) & mask;
        do_push = bus_valid && bus_write  && (rg == RG_PORT);
        do_pop  = bus_valid && !bus_write && (rg == RG_PORT);
        push_ok = !((wsub[qi] == 2'd0) && (cnt[qi] == sw));
        pop_ok  = !((rsub[qi] == 2'd0) && (cnt[qi] == '0));
        mem_we  = (bus_valid && bus_write && (rg == RG_SRAM)) || (do_push && push_ok);
        if (rg == RG_SRAM) mem_addr = bus_addr[MEM_AW-1:0];
        else               mem_addr = c.base + MEM_AW'(do_push ? woff : roff);
        case (rg)
            RG_CFG:  side_d = c;
            RG_STAT: side_d = {16'b0, cnt[qi], 2'b0, ofl[qi], ufl[qi], flags[qi]};
            default: side_d = '0;
        endcase
    end

    qring_sram #(.AW(MEM_AW), .W(DW)) u_sram (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (bus_wdata),
        .rdata (mem_rdata)
    );

    qring_flags #(.NQ(NQ)) u_flags (
        .clk      (clk),
        .rst      (rst),
        .cfg      (cfg_q),
        .cnt      (cnt),
        .flags    (flags),
        .sel_cond (sel_cond),
        .en_vec   (en_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_mem_q <= 1'b0;
            side_q   <= '0;
        end else if (bus_valid && !bus_write) begin
            rd_mem_q <= (rg == RG_SRAM) || (do_pop && pop_ok);
            side_q   <= side_d;
        end
    end

    assign bus_rdata = rd_mem_q ? mem_rdata : side_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int q = 0; q < NQ; q++) begin
                cfg_q[q] <= '0;
                wptr[q]  <= '0;
                rptr[q]  <= '0;
                cnt[q]   <= '0;
                wsub[q]  <= '0;
                rsub[q]  <= '0;
            end
            ufl <= '0;
            ofl <= '0;
        end else if (bus_valid) begin
            if (rg == RG_CFG && bus_write) begin
                cfg_q[qi] <= qcfg_t'(bus_wdata);
                wptr[qi]  <= '0;
                rptr[qi]  <= '0;
                cnt[qi]   <= '0;
                wsub[qi]  <= '0;
                rsub[qi]  <= '0;
                ufl[qi]   <= 1'b0;
                ofl[qi]   <= 1'b0;
            end else if (rg == RG_STAT && bus_write) begin
                if (bus_wdata[4]) ufl[qi] <= 1'b0;
                if (bus_wdata[5]) ofl[qi] <= 1'b0;
            end else if (do_push) begin
                if (!push_ok) ofl[qi] <= 1'b1;
                else if (3'(wsub[qi]) == ew - 3'd1) begin
                    wptr[qi] <= (wptr[qi] + OFF_W'(ew)) & mask;
                    cnt[qi]  <= cnt[qi] + CNT_W'(ew);
                    wsub[qi] <= '0;
                end else wsub[qi] <= wsub[qi] + 2'd1;
            end else if (do_pop) begin
                if (!pop_ok) ufl[qi] <= 1'b1;
                else if (3'(rsub[qi]) == ew - 3'd1) begin
                    rptr[qi] <= (rptr[qi] + OFF_W'(ew)) & mask;
                    cnt[qi]  <= cnt[qi] - CNT_W'(ew);
                    rsub[qi] <= '0;
                end else rsub[qi] <= rsub[qi] + 2'd1;
            end
        end
    end

    assign lo_flags = sel_cond[HALF-1:0];
    assign hi_event = |sel_cond[NQ-1:HALF];
    assign irq_lo   = |(sel_cond[HALF-1:0] & en_vec[HALF-1:0]);
    assign irq_hi   = |(sel_cond[NQ-1:HALF] & en_vec[NQ-1:HALF]);

    // R4
    drop_sets_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (do_push && !push_ok) |=> ofl[$past(qi)]);

    // R5
    empty_pop_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (do_pop && !pop_ok) |=> (bus_rdata == '0));

    // R3
    commit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (do_push && push_ok && (3'(wsub[qi]) == ew - 3'd1))
        |=> (cnt[$past(qi)] == $past(cnt[qi]) + CNT_W'($past(ew))));

    // R12
    reset_rdata_chk: assert property (@(posedge clk)
        rst |=> (bus_rdata == '0));
endmodule

// File: tb/qring_mgr_tb_top.sv
module qring_mgr_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [13:0] bus_addr  = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] lo_flags;
    logic        hi_event, irq_lo, irq_hi;

    always #2.5 clk = ~clk;

    qring_mgr dut_i (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .lo_flags(lo_flags), .hi_event(hi_event), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    int checks = 0, failures = 0;
    bit live = 0;

    // behavioural model
    logic [31:0] m_cfg [64];
    logic [31:0] dq [64][$];
    logic [31:0] st [64][$];
    int          rsub [64];
    bit          uf [64], of [64];
    logic [31:0] mmem [int];
    logic [31:0] exp_rd;

    function automatic int m_sz(int q);  return 16 << m_cfg[q][12:11]; endfunction
    function automatic int m_ew(int q);  return (m_cfg[q][14:13] == 0) ? 1 : (m_cfg[q][14:13] == 1) ? 2 : 4; endfunction
    function automatic int m_cnt(int q); return dq[q].size() + rsub[q]; endfunction

    function automatic logic [3:0] m_flags(int q);
        int c, e;
        c = m_cnt(q);
        e = c / m_ew(q);
        return {c == m_sz(q), e >= int'(m_cfg[q][28:22]), e <= int'(m_cfg[q][21:15]), c == 0};
    endfunction

    function automatic bit m_sel(int q);
        logic [3:0] f;
        f = m_flags(q);
        return f[m_cfg[q][31:30]];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [13:0] mkaddr(int rg, int idx);
        return {2'(rg), 12'(idx)};
    endfunction

    task automatic model_apply(int rg, int idx, bit wr, logic [31:0] d);
        int q;
        q = idx % 64;
        case (rg)
            0: if (wr) mmem[idx] = d; else exp_rd = mmem[idx];
            1: if (wr) begin
                   if (st[q].size() == 0 && m_cnt(q) == m_sz(q)) of[q] = 1;
                   else begin
                       st[q].push_back(d);
                       if (st[q].size() == m_ew(q)) begin
                           while (st[q].size() > 0) dq[q].push_back(st[q].pop_front());
                       end
                   end
               end else begin
                   if (rsub[q] == 0 && m_cnt(q) == 0) begin
                       uf[q] = 1; exp_rd = 0;
                   end else begin
                       exp_rd = dq[q].pop_front();
                       rsub[q]++;
                       if (rsub[q] == m_ew(q)) rsub[q] = 0;
                   end
               end
            2: if (wr) begin
                   m_cfg[q] = d; dq[q].delete(); st[q].delete();
                   rsub[q] = 0; uf[q] = 0; of[q] = 0;
               end else exp_rd = m_cfg[q];
            default: if (wr) begin
                   if (d[4]) uf[q] = 0;
                   if (d[5]) of[q] = 0;
               end else exp_rd = {16'b0, 8'(m_cnt(q)), 2'b0, of[q], uf[q], m_flags(q)};
        endcase
    endtask

    task automatic op(int rg, int idx, bit wr, logic [31:0] d, output logic [31:0] rd);
        @(negedge clk);
        bus_valid = 1; bus_write = wr; bus_addr = mkaddr(rg, idx); bus_wdata = d;
        @(posedge clk);
        #1;
        bus_valid = 0;
        model_apply(rg, idx, wr, d);
        @(negedge clk);
        rd = bus_rdata;
    endtask

    task automatic wr_op(int rg, int idx, logic [31:0] d);
        logic [31:0] r;
        op(rg, idx, 1, d, r);
    endtask

    task automatic rd_chk(string req, int rg, int idx);
        logic [31:0] r;
        op(rg, idx, 0, 0, r);
        chk(req, r, exp_rd);
    endtask

    // per-cycle comparison of the status outputs (R8, R9, R10)
    always @(negedge clk) begin
        if (live) begin
            logic [31:0] lf;
            bit he, il, ih;
            he = 0; il = 0; ih = 0;
            for (int q = 0; q < 64; q++) begin
                if (q < 32) begin
                    lf[q] = m_sel(q);
                    il |= m_sel(q) & m_cfg[q][29];
                end else begin
                    he |= m_sel(q);
                    ih |= m_sel(q) & m_cfg[q][29];
                end
            end
            chk("R8 lo_flags", lo_flags, lf);
            chk("R9 hi_event", 32'(hi_event), 32'(he));
            chk("R10 irq_lo", 32'(irq_lo), 32'(il));
            chk("R10 irq_hi", 32'(irq_hi), 32'(ih));
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    localparam logic [31:0] CFG1  = (32'd2 << 30) | (32'd1 << 29) | (32'd14 << 22) | (32'd2 << 15) | 32'h100;
    localparam logic [31:0] CFG40 = (32'd3 << 30) | (32'd1 << 29) | (32'd6 << 22) | (32'd1 << 15)
                                  | (32'd2 << 13) | (32'd1 << 11) | 32'h200;
    localparam logic [31:0] CFGUP = (32'd3 << 30);

    initial begin
        for (int q = 0; q < 64; q++) begin
            m_cfg[q] = 0; rsub[q] = 0; uf[q] = 0; of[q] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R12 reset state
        chk("R12 rdata after reset", bus_rdata, 32'h0);
        live = 1;
        rd_chk("R12 status after reset", 3, 0);
        rd_chk("R12 cfg after reset", 2, 5);

        // R11 raw SRAM
        wr_op(0, 12'h7F0, 32'hCAFE_F00D);
        wr_op(0, 12'h7F1, 32'h1234_5678);
        rd_chk("R11 raw read", 0, 12'h7F0);
        rd_chk("R11 raw read", 0, 12'h7F1);

        // R1 config queue 1
        wr_op(2, 1, CFG1);
        rd_chk("R1 cfg readback", 2, 1);
        rd_chk("R7 status empty", 3, 1);

        // R2 fill, R4 overflow
        for (int i = 0; i < 16; i++) wr_op(1, 1, 32'hA100_0000 + i);
        rd_chk("R7 status full", 3, 1);
        wr_op(1, 1, 32'hDEAD_0001);
        rd_chk("R4 overflow sticky", 3, 1);
        for (int i = 0; i < 16; i++) rd_chk("R2 pop order", 1, 1);
        rd_chk("R5 empty pop zero", 1, 1);
        rd_chk("R5 underflow sticky", 3, 1);
        wr_op(3, 1, 32'h10);
        rd_chk("R6 clear underflow only", 3, 1);
        wr_op(3, 1, 32'h20);
        rd_chk("R6 clear overflow", 3, 1);

        // R2 wraparound after partial fill
        for (int i = 0; i < 5; i++) wr_op(1, 1, 32'hB100_0000 + i);
        for (int i = 0; i < 5; i++) rd_chk("R2 pop order", 1, 1);
        for (int i = 0; i < 16; i++) wr_op(1, 1, 32'hC100_0000 + i);
        for (int i = 0; i < 16; i++) rd_chk("R2 wrap order", 1, 1);

        // R9 upper queues select full
        for (int q = 32; q < 64; q++) wr_op(2, q, CFGUP);
        wr_op(2, 40, CFG40);

        // R3 multi-word commit
        for (int i = 0; i < 3; i++) wr_op(1, 40, 32'hD400_0000 + i);
        rd_chk("R3 partial entry invisible", 3, 40);
        wr_op(1, 40, 32'hD400_0003);
        rd_chk("R3 entry committed", 3, 40);
        for (int i = 4; i < 32; i++) wr_op(1, 40, 32'hD400_0000 + i);
        rd_chk("R7 status full 4w", 3, 40);
        wr_op(1, 40, 32'hDEAD_0002);
        rd_chk("R4 overflow 4w", 3, 40);
        rd_chk("R3 pop word", 1, 40);
        rd_chk("R3 pop word", 1, 40);
        rd_chk("R3 count held mid entry", 3, 40);
        rd_chk("R3 pop word", 1, 40);
        rd_chk("R3 pop word", 1, 40);
        rd_chk("R3 count after entry", 3, 40);
        for (int i = 0; i < 28; i++) rd_chk("R2 pop order 4w", 1, 40);
        rd_chk("R5 empty pop zero 4w", 1, 40);

        // R1 reconfig clears state
        for (int i = 0; i < 4; i++) wr_op(1, 1, 32'hE100_0000 + i);
        wr_op(2, 1, CFG1);
        rd_chk("R1 reconfig empties", 3, 1);
        rd_chk("R11 raw read again", 0, 12'h7F0);

        repeat (2) @(negedge clk);
        live = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule